// File: doc/BRIEF.md
# GF(2^m) Dual-Exponent Power Engine

This block raises two field elements to two independent exponents and multiplies the results, returning Z = A^K · B^H over GF(2^m) in polynomial basis, with the reduction polynomial given at the port. The whole computation runs on one folded squaring core that evaluates X · Y² mod P, consuming T bits of Y per clock. A result therefore takes ceil(M/T) cycles per pass. No general multiplier exists in the block.

A run begins with two passes that form the product A·B. The first pass squares the even-indexed bits of B against A. The second squares the odd-indexed bits against A·x. The two partial results are XORed. Then M squaring passes follow, scanning K and H together from the most significant bit down. Each pass multiplies the running value squared by 1, B, A or A·B, chosen by the current bit pair. The result is registered on `z_o` and flagged with a one-cycle `done_o` pulse.

Top module: `gf2m_dual_pow`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `z_o` is 0 and `done_o` is 0.
- R2: Every operand and `poly_i` use bit j as the coefficient of x^j. `poly_i` holds the coefficients below x^M, and x^M is implied. After a run, `z_o` equals A^K·B^H mod P, where A, B, K and H are the values sampled with the start.
- R3: `done_o` is high for exactly one cycle. It is high in the cycle after the (M+2)·ceil(M/T)-th rising edge that follows the edge accepting `start_i`, and low at all other times.
- R4: When K and H are both zero, the result is 1.
- R5: `z_o` keeps its value between `done_o` pulses, whatever the inputs do.
- R6: A `start_i` raised while a run is in progress is ignored, and so are changes to any operand input. The current result and its timing are unaffected.
- R7: A `start_i` raised in the same cycle that `done_o` is high is accepted. It begins a new run with the usual latency.
- R8: Corner operands give field-correct results. A = 0 with K ≠ 0 yields 0, and B = 1 with K = 0 yields 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run; sampled only while idle |
| a_i | input | M | Base A |
| b_i | input | M | Base B |
| k_i | input | M | Exponent applied to A |
| h_i | input | M | Exponent applied to B |
| poly_i | input | M | Reduction polynomial, coefficients of x^0..x^(M-1) |
| z_o | output | M | Result A^K·B^H |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
Two events can share a cycle: the completion pulse of one run and the acceptance of the next start. The bench raises `start_i` in the very cycle where `done_o` is seen high. It then judges that the old result was correct and that the new run returns its own value after exactly the nominal latency. A second collision places a start, with fresh operands, in the middle of a busy run. That start must leave both the result and the completion time of the run in progress unchanged. Around these, every pair of bases for a 5-bit field is swept against an arithmetic square-and-multiply model in the bench.

// File: rtl/gfdx_pkg.sv
package gfdx_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} dx_state_e;
  // code is {k_bit, h_bit}
  typedef enum logic [1:0] {OP_ONE = 2'b00, OP_B = 2'b01, OP_A = 2'b10, OP_AB = 2'b11} op_sel_e;
endpackage

// File: rtl/gfdx_sq_core.sv
module gfdx_sq_core #(
  parameter int M = 8,
  parameter int T = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [M-1:0] ia_i,
  input  logic [T-1:0] dig_i,
  input  logic [M-1:0] poly_i,
  output logic [M-1:0] res_o
);
  function automatic logic [M-1:0] times_x(input logic [M-1:0] v, input logic [M-1:0] p);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? p : '0);
  endfunction

  logic [M-1:0] acc_q;
  logic [M-1:0] chain [T+1];

  assign chain[0] = clr_i ? '0 : acc_q;

  // one folded stage per digit bit, MSB of the digit first
  for (genvar s = 0; s < T; s++) begin : g_stage
    assign chain[s+1] = times_x(times_x(chain[s], poly_i), poly_i)
                      ^ (dig_i[T-1-s] ? ia_i : '0);
  end

  assign res_o = chain[T];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= res_o;
  end
endmodule

// File: rtl/gfdx_pts.sv
module gfdx_pts #(
  parameter int M = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [M-1:0] val_i,
  output logic         msb_o
);
  logic [M-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= val_i;
    else if (shift_i) sr_q <= {sr_q[M-2:0], 1'b0};
  end

  assign msb_o = sr_q[M-1];
endmodule

// File: rtl/gfdx_opsel.sv
module gfdx_opsel
  import gfdx_pkg::*;
#(
  parameter int M = 8
) (
  input  logic         k_bit_i,
  input  logic         h_bit_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  input  logic [M-1:0] ab_i,
  output logic [M-1:0] op_o
);
  localparam logic [M-1:0] ONE = {{(M-1){1'b0}}, 1'b1};

  always_comb begin
    case (op_sel_e'({k_bit_i, h_bit_i}))
      OP_ONE:  op_o = ONE;
      OP_B:    op_o = b_i;
      OP_A:    op_o = a_i;
      default: op_o = ab_i;
    endcase
  end
endmodule

// File: rtl/gf2m_dual_pow.sv
module gf2m_dual_pow
  import gfdx_pkg::*;
#(
  parameter int M = 8,
  parameter int T = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  input  logic [M-1:0] k_i,
  input  logic [M-1:0] h_i,
  input  logic [M-1:0] poly_i,
  output logic [M-1:0] z_o,
  output logic         done_o
);
  localparam int N         = (M + T - 1) / T;
  localparam int IBW       = N * T;
  localparam int HALF      = (M + 1) / 2;
  localparam int CW        = (N > 1) ? $clog2(N) : 1;
  localparam int PW        = $clog2(M + 2);
  localparam int LAST_PASS = M + 1;
  localparam logic [M-1:0] ONE = {{(M-1){1'b0}}, 1'b1};

  dx_state_e     state_q;
  logic [PW-1:0] pass_q;
  logic [CW-1:0] cyc_q;
  logic [M-1:0]  a_q, b_q, p_q, y1_q, d_q, c_q, z_q;
  logic          done_q;

  logic          accept, last_cyc, sq_pass, run;
  logic          k_bit, h_bit;
  logic [M-1:0]  a_x, sel_op, ia, res;
  logic [HALF-1:0] b_even, b_odd;
  logic [IBW-1:0]  ib_pad;
  logic [T-1:0]    dig;

  assign run      = (state_q == ST_RUN);
  assign accept   = (state_q == ST_IDLE) && start_i;
  assign last_cyc = run && (cyc_q == CW'(N - 1));
  assign sq_pass  = (pass_q >= PW'(2));

  // A times x, for the odd-bit half of the product
  assign a_x = {a_q[M-2:0], 1'b0} ^ (a_q[M-1] ? p_q : '0);

  for (genvar j = 0; j < HALF; j++) begin : g_split
    assign b_even[j] = b_q[2*j];
    if (2*j + 1 < M) begin : g_odd
      assign b_odd[j] = b_q[2*j+1];
    end else begin : g_pad
      assign b_odd[j] = 1'b0;
    end
  end

  gfdx_pts #(.M(M)) u_kbits (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept),
    .shift_i(last_cyc && sq_pass), .val_i(k_i), .msb_o(k_bit)
  );

  gfdx_pts #(.M(M)) u_hbits (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept),
    .shift_i(last_cyc && sq_pass), .val_i(h_i), .msb_o(h_bit)
  );

  gfdx_opsel #(.M(M)) u_opsel (
    .k_bit_i(k_bit), .h_bit_i(h_bit), .a_i(a_q), .b_i(b_q),
    .ab_i(d_q), .op_o(sel_op)
  );

  always_comb begin
    ib_pad = '0;
    if (pass_q == PW'(0)) begin
      ia                 = a_q;
      ib_pad[HALF-1:0]   = b_even;
    end else if (pass_q == PW'(1)) begin
      ia                 = a_x;
      ib_pad[HALF-1:0]   = b_odd;
    end else begin
      ia                 = sel_op;
      ib_pad[M-1:0]      = c_q;
    end
  end

  assign dig = ib_pad[(N - 1 - int'(cyc_q)) * T +: T];

  gfdx_sq_core #(.M(M), .T(T)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(run), .clr_i(cyc_q == '0),
    .ia_i(ia), .dig_i(dig), .poly_i(p_q), .res_o(res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
      cyc_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      p_q     <= '0;
      y1_q    <= '0;
      d_q     <= '0;
      c_q     <= ONE;
      z_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        pass_q  <= '0;
        cyc_q   <= '0;
        a_q     <= a_i;
        b_q     <= b_i;
        p_q     <= poly_i;
        c_q     <= ONE;
      end else if (run) begin
        cyc_q <= last_cyc ? '0 : cyc_q + 1'b1;
        if (last_cyc) begin
          pass_q <= pass_q + 1'b1;
          if (pass_q == PW'(0))      y1_q <= res;
          else if (pass_q == PW'(1)) d_q  <= y1_q ^ res;
          else                       c_q  <= res;
          if (pass_q == PW'(LAST_PASS)) begin
            z_q     <= res;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      end
    end
  end

  assign z_o    = z_q;
  assign done_o = done_q;
endmodule

// File: rtl/gfdx_chk.sv
module gfdx_chk #(
  parameter int M = 8,
  parameter int T = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         done_o,
  input logic [M-1:0] z_o
);
  localparam int N   = (M + T - 1) / T;
  localparam int LAT = (M + 2) * N;
  localparam int CNW = $clog2(LAT + 1) + 1;

  logic           run_q;
  logic [CNW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q && start_i) begin
      run_q <= 1'b1;
      cnt_q <= CNW'(1);
    end else if (run_q) begin
      if (cnt_q == CNW'(LAT)) run_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_DONE_ON_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q == CNW'(LAT)) |=> done_o); // R3
  AST_NO_EARLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> !done_o); // R3
  AST_Z_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(z_o)); // R5
endmodule

bind gf2m_dual_pow gfdx_chk #(.M(M), .T(T)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .done_o(done_o), .z_o(z_o)
);

// File: tb/gf2m_dual_pow_tb.sv
`timescale 1ns/1ps
module gf2m_dual_pow_tb;
  localparam int M   = 5;
  localparam int T   = 2;
  localparam int N   = (M + T - 1) / T;
  localparam int LAT = (M + 2) * N;
  localparam logic [M-1:0] POLY = 5'b00101; // x^5 + x^2 + 1

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [M-1:0] a_i = '0, b_i = '0, k_i = '0, h_i = '0, poly_i = POLY;
  logic [M-1:0] z_o;
  logic         done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gf2m_dual_pow #(.M(M), .T(T)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .a_i(a_i), .b_i(b_i),
    .k_i(k_i), .h_i(h_i), .poly_i(poly_i), .z_o(z_o), .done_o(done_o)
  );

  function automatic logic [M-1:0] mx(input logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY : '0);
  endfunction

  function automatic logic [M-1:0] gmul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [M-1:0] r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = mx(r);
      if (y[i]) r = r ^ x;
    end
    return r;
  endfunction

  function automatic logic [M-1:0] model(input logic [M-1:0] a, b, k, h);
    logic [M-1:0] c = 1;
    for (int i = M - 1; i >= 0; i--) begin
      c = gmul(c, c);
      if (k[i]) c = gmul(c, a);
      if (h[i]) c = gmul(c, b);
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_run(input logic [M-1:0] a, b, k, h);
    a_i = a; b_i = b; k_i = k; h_i = h;
    start_i = 1'b1;
  endtask

  task automatic wait_done(input bit chk_fall, output int lat, output logic [M-1:0] zv);
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (lat == 1) start_i = 1'b0;
      if (done_o) break;
      if (lat > 500) begin
        check(1'b0, "R3 timeout", lat, LAT + 1);
        break;
      end
    end
    zv = z_o;
    if (chk_fall) begin
      @(negedge clk);
      check(!done_o, "R3 done single cycle", int'(done_o), 0);
    end
  endtask

  task automatic run_check(input logic [M-1:0] a, b, k, h, input string req);
    int lat;
    logic [M-1:0] zv, ex;
    ex = model(a, b, k, h);
    start_run(a, b, k, h);
    wait_done(1'b1, lat, zv);
    check(zv == ex, req, int'(zv), int'(ex));
    check(lat == LAT + 1, "R3 latency", lat, LAT + 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog all", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    logic [M-1:0] zv, ex;
    repeat (3) @(negedge clk);
    check(z_o == '0 && !done_o, "R1 in reset", int'(z_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(z_o == '0 && !done_o, "R1 after reset", int'(z_o), 0);

    // R4 zero exponents
    run_check(5'd19, 5'd7, 5'd0, 5'd0, "R4 K=H=0");
    check(z_o == 5'd1, "R4 value one", int'(z_o), 1);
    // R8 corners
    run_check(5'd0, 5'd1, 5'd31, 5'd0, "R8 A=0 K=all ones");
    check(z_o == '0, "R8 zero base", int'(z_o), 0);
    run_check(5'd13, 5'd1, 5'd0, 5'd22, "R8 B=1 K=0");
    check(z_o == 5'd1, "R8 unit base", int'(z_o), 1);
    run_check(5'd9, 5'd1, 5'd31, 5'd31, "R8 B=1 K=H=all ones");

    // R5 hold while inputs move without start
    ex = z_o;
    a_i = 5'd3; b_i = 5'd17; k_i = 5'd6; h_i = 5'd29;
    repeat (6) @(negedge clk);
    check(z_o == ex && !done_o, "R5 result held", int'(z_o), int'(ex));

    // R6 start and operand changes while busy
    ex = model(5'd11, 5'd26, 5'd21, 5'd10);
    start_run(5'd11, 5'd26, 5'd21, 5'd10);
    @(negedge clk); start_i = 1'b0;
    lat = 1;
    repeat (3) begin @(negedge clk); lat++; end
    start_run(5'd30, 5'd2, 5'd7, 5'd1);
    @(negedge clk); lat++; start_i = 1'b0;
    while (!done_o && lat < 500) begin @(negedge clk); lat++; end
    check(z_o == ex, "R6 busy start ignored", int'(z_o), int'(ex));
    check(lat == LAT + 1, "R6 timing kept", lat, LAT + 1);
    @(negedge clk);

    // R7 start in the done cycle
    ex = model(5'd4, 5'd23, 5'd18, 5'd12);
    start_run(5'd4, 5'd23, 5'd18, 5'd12);
    wait_done(1'b0, lat, zv);
    check(zv == ex, "R7 first result", int'(zv), int'(ex));
    ex = model(5'd27, 5'd5, 5'd9, 5'd30);
    start_run(5'd27, 5'd5, 5'd9, 5'd30);
    wait_done(1'b1, lat, zv);
    check(zv == ex, "R7 back-to-back result", int'(zv), int'(ex));
    check(lat == LAT + 1, "R7 back-to-back latency", lat, LAT + 1);

    // R2 sweep over every base pair
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        logic [M-1:0] kk, hh;
        kk = M'((a * 7 + b * 3 + 1) % 32);
        hh = M'((a * 5 + b * 11 + 2) % 32);
        run_check(M'(a), M'(b), kk, hh, "R2 sweep");
        case ((a + b) % 4)
          0: begin kk = 5'd0;  hh = 5'd0;  end
          1: begin kk = 5'd31; hh = 5'd0;  end
          2: begin kk = 5'd0;  hh = 5'd31; end
          default: begin kk = 5'd31; hh = 5'd31; end
        endcase
        run_check(M'(a), M'(b), kk, hh, "R2 edge exponents");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule